// File: doc/BRIEF.md
# Direct Branch Decoder and Target Unit

This unit sits behind instruction fetch and inspects one fetched word per cycle. It is told whether the core is running the fixed 32-bit instruction set or the mixed 16/32-bit set. It also receives the address of the word, the four condition flags and the state of a conditional-execution window. It recognises the five direct-branch forms. For each one it rebuilds the signed byte displacement from the form's own immediate layout, adds it to the program-counter view of the instruction, and decides from the condition code whether the branch is taken.

Some words share an opcode space with branches but belong to other instructions. The unit reports these through a redirect code instead of a branch, so that decode can send them to the permanently-undefined handler, the system-call handler or the related-instruction group. Branches that are used inside a conditional window in a way the architecture does not define raise an unpredictable flag. All results are registered, one cycle after the word is presented.

Top module: `br_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: `br_valid`, `br_taken`, `br_target`, `br_enc` (0 = none), `br_rdir` (0 = none) and `br_unpred`.
- R2: In fixed mode (`mode_mixed`=0), a word with bits [27:24]=1010 and condition bits [31:28] not 1111 is a branch with `br_enc`=1. Its displacement is bits [23:0] followed by two zero bits, sign-extended, and its program-counter base is `iaddr`+8. With bits [31:28]=1111 the word is not a branch.
- R3: In mixed mode, a first halfword (`instr[15:0]`) with bits [15:12]=1101 is the short conditional form (`br_enc`=2). Its condition is bits [11:8], and its displacement is bits [7:0] followed by one zero bit, sign-extended.
- R4: For the short conditional form, condition value 1110 gives `br_rdir`=1 (permanently undefined) and 1111 gives `br_rdir`=2 (system call), with `br_valid` low.
- R5: In mixed mode, a first halfword with bits [15:11]=11100 is the short unconditional form (`br_enc`=3). Its displacement is bits [10:0] followed by one zero bit, sign-extended.
- R6: In mixed mode, a first halfword with bits [15:11]=11110 and a second halfword (`instr[31:16]`) with bits [15:14]=10 and bit 12=0 is the long conditional form (`br_enc`=4). Its condition is first-halfword bits [9:6]. Its displacement is S:J2:J1:imm6:imm11:0, sign-extended, where S=hw1[10], imm6=hw1[5:0], J1=hw2[13], J2=hw2[11] and imm11=hw2[10:0].
- R7: A long conditional word whose condition bits [9:7] are 111 gives `br_rdir`=3 (related instruction) with `br_valid` low.
- R8: The same layout with hw2[12]=1 is the long unconditional form (`br_enc`=5). Its displacement is S:I1:I2:imm10:imm11:0, sign-extended, with I1=NOT(J1 XOR S), I2=NOT(J2 XOR S) and imm10=hw1[9:0].
- R9: In mixed mode the program-counter base is `iaddr`+4, and `br_target` is that base plus the displacement, modulo 2^32.
- R10: `br_taken` is set only for a valid branch whose condition passes. `flags` holds N,Z,C,V in bits 3..0. Codes 0..13 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT and LE; 14 and 15 always pass.
- R11: For mixed-mode branches, `blk_active` high selects `blk_cond` as the condition. Outside a window the unconditional forms always pass. Fixed-mode branches always use their own condition field and ignore the window inputs.
- R12: `br_unpred` is set for forms 2 and 4 whenever `blk_active` is high, and for forms 3 and 5 when `blk_active` is high and `blk_last` is low. It is never set without `br_valid`.
- R13: With `in_valid` low, or with a word that is neither a branch nor a redirect, all outputs read zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Presented word is meaningful |
| mode_mixed | input | 1 | 0 = fixed 32-bit set, 1 = mixed 16/32-bit set |
| instr | input | 32 | Fetched word; in mixed mode [15:0] is the first halfword |
| iaddr | input | ADDR_W | Address of the instruction |
| flags | input | 4 | N, Z, C, V in bits 3..0 |
| blk_active | input | 1 | Instruction lies inside a conditional window |
| blk_last | input | 1 | Instruction is the last one of the window |
| blk_cond | input | 4 | Condition imposed by the window |
| br_valid | output | 1 | A direct branch was recognised |
| br_taken | output | 1 | Branch condition passed |
| br_target | output | ADDR_W | Branch destination address |
| br_enc | output | 3 | Branch form identifier, 0 when none |
| br_rdir | output | 2 | Redirect code for a non-branch word in branch space |
| br_unpred | output | 1 | Branch used in an undefined way inside a window |

## Verification
The assertions assume that `in_valid`, `mode_mixed`, `iaddr` and the window inputs are driven to known values from the first clock edge on. They also assume that `blk_last` is only meaningful while `blk_active` is high. Stimulus changes every input only on the falling edge, holds it through the next rising edge, and keeps `blk_last` low outside a window. All instruction words come from field-level builders, plus a few hand-written second halfwords that set the J bits directly.

// File: rtl/br_pkg.sv
`timescale 1ns/1ps
package br_pkg;

    typedef enum logic [2:0] {
        ENC_NONE = 3'd0,
        ENC_W32  = 3'd1,
        ENC_H16C = 3'd2,
        ENC_H16U = 3'd3,
        ENC_M32C = 3'd4,
        ENC_M32U = 3'd5
    } br_enc_e;

    typedef enum logic [1:0] {
        RDIR_NONE       = 2'd0,
        RDIR_PERM_UNDEF = 2'd1,
        RDIR_SYSCALL    = 2'd2,
        RDIR_RELATED    = 2'd3
    } br_rdir_e;

    localparam logic [3:0] COND_ALWAYS = 4'b1110;
    localparam int         INSTR_W     = 32;
    localparam int         NUM_LANES   = 5;
    localparam int         RAW_W       = 26;

endpackage

// File: rtl/br_cond_eval.sv
`timescale 1ns/1ps
module br_cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n_f, z_f, c_f, v_f;
    logic base;

    assign {n_f, z_f, c_f, v_f} = flags;

    always_comb begin
        unique case (cond[3:1])
            3'd0:    base = z_f;
            3'd1:    base = c_f;
            3'd2:    base = n_f;
            3'd3:    base = v_f;
            3'd4:    base = c_f & ~z_f;
            3'd5:    base = (n_f == v_f);
            3'd6:    base = ~z_f & (n_f == v_f);
            default: base = 1'b1;
        endcase
        // odd codes invert, except the always-pass pair
        if (cond[0] && (cond[3:1] != 3'b111)) begin
            pass = ~base;
        end else begin
            pass = base;
        end
    end
endmodule

// File: rtl/br_decode.sv
`timescale 1ns/1ps
module br_decode
    import br_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic                mode_mixed,
    input  logic [INSTR_W-1:0]  instr,
    output br_enc_e             enc,
    output br_rdir_e            rdir,
    output logic                has_cond,
    output logic [3:0]          own_cond,
    output logic [OFF_W-1:0]    offset
);
    localparam int LANE_W [NUM_LANES] = '{26, 9, 12, 21, 25};

    logic [15:0]      hw1;
    logic [15:0]      hw2;
    logic             sbit;
    logic             wide_prefix;
    logic [RAW_W-1:0] raw      [NUM_LANES];
    logic [OFF_W-1:0] lane_off [NUM_LANES];

    assign hw1  = instr[15:0];
    assign hw2  = instr[31:16];
    assign sbit = hw1[10];
    assign wide_prefix = (hw1[15:13] == 3'b111) && (hw1[12:11] != 2'b00);

    // right-aligned immediate fields, one lane per branch form
    assign raw[0] = {instr[23:0], 2'b00};
    assign raw[1] = RAW_W'({hw1[7:0], 1'b0});
    assign raw[2] = RAW_W'({hw1[10:0], 1'b0});
    assign raw[3] = RAW_W'({sbit, hw2[11], hw2[13], hw1[5:0], hw2[10:0], 1'b0});
    assign raw[4] = RAW_W'({sbit, ~(hw2[13] ^ sbit), ~(hw2[11] ^ sbit),
                            hw1[9:0], hw2[10:0], 1'b0});

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            localparam int SHIFT = RAW_W - LANE_W[g];
            logic signed [RAW_W-1:0] aligned;
            assign aligned     = $signed(raw[g] << SHIFT);
            assign lane_off[g] = OFF_W'(aligned >>> SHIFT);
        end
    endgenerate

    always_comb begin
        enc      = ENC_NONE;
        rdir     = RDIR_NONE;
        has_cond = 1'b0;
        own_cond = COND_ALWAYS;
        if (!mode_mixed) begin
            if ((instr[27:24] == 4'b1010) && (instr[31:28] != 4'b1111)) begin
                enc      = ENC_W32;
                has_cond = 1'b1;
                own_cond = instr[31:28];
            end
        end else if (wide_prefix) begin
            if ((hw1[15:11] == 5'b11110) && (hw2[15:14] == 2'b10)) begin
                if (hw2[12]) begin
                    enc = ENC_M32U;
                end else if (hw1[9:7] == 3'b111) begin
                    rdir = RDIR_RELATED;
                end else begin
                    enc      = ENC_M32C;
                    has_cond = 1'b1;
                    own_cond = hw1[9:6];
                end
            end
        end else if (hw1[15:12] == 4'b1101) begin
            if (hw1[11:8] == 4'b1110) begin
                rdir = RDIR_PERM_UNDEF;
            end else if (hw1[11:8] == 4'b1111) begin
                rdir = RDIR_SYSCALL;
            end else begin
                enc      = ENC_H16C;
                has_cond = 1'b1;
                own_cond = hw1[11:8];
            end
        end else if (hw1[15:11] == 5'b11100) begin
            enc = ENC_H16U;
        end
    end

    always_comb begin
        unique case (enc)
            ENC_W32:  offset = lane_off[0];
            ENC_H16C: offset = lane_off[1];
            ENC_H16U: offset = lane_off[2];
            ENC_M32C: offset = lane_off[3];
            ENC_M32U: offset = lane_off[4];
            default:  offset = '0;
        endcase
    end
endmodule

// File: rtl/br_target_add.sv
`timescale 1ns/1ps
module br_target_add #(
    parameter int ADDR_W    = 32,
    parameter int FIXED_ADV = 8,
    parameter int MIXED_ADV = 4
) (
    input  logic              mode_mixed,
    input  logic [ADDR_W-1:0] iaddr,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] target
);
    localparam logic [ADDR_W-1:0] ADV_FIXED = ADDR_W'(FIXED_ADV);
    localparam logic [ADDR_W-1:0] ADV_MIXED = ADDR_W'(MIXED_ADV);

    logic [ADDR_W-1:0] pc_view;

    assign pc_view = iaddr + (mode_mixed ? ADV_MIXED : ADV_FIXED);
    assign target  = pc_view + offset;
endmodule

// File: rtl/br_unit.sv
`timescale 1ns/1ps
module br_unit
    import br_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FIXED_ADV = 8,
    parameter int MIXED_ADV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode_mixed,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] iaddr,
    input  logic [3:0]        flags,
    input  logic              blk_active,
    input  logic              blk_last,
    input  logic [3:0]        blk_cond,
    output logic              br_valid,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic [2:0]        br_enc,
    output logic [1:0]        br_rdir,
    output logic              br_unpred
);
    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [ADDR_W-1:0] target;
        br_enc_e           enc;
        br_rdir_e          rdir;
        logic              unpred;
    } br_state_t;

    br_state_t state_d, state_q;

    br_enc_e           dec_enc;
    br_rdir_e          dec_rdir;
    logic              dec_has_cond;
    logic [3:0]        dec_cond;
    logic [ADDR_W-1:0] dec_off;
    logic [ADDR_W-1:0] calc_target;
    logic [3:0]        eff_cond;
    logic              cond_pass;
    logic              is_cond_mixed;
    logic              is_uncond_mixed;

    br_decode #(.OFF_W(ADDR_W)) u_decode (
        .mode_mixed (mode_mixed),
        .instr      (instr),
        .enc        (dec_enc),
        .rdir       (dec_rdir),
        .has_cond   (dec_has_cond),
        .own_cond   (dec_cond),
        .offset     (dec_off)
    );

    br_target_add #(
        .ADDR_W    (ADDR_W),
        .FIXED_ADV (FIXED_ADV),
        .MIXED_ADV (MIXED_ADV)
    ) u_target (
        .mode_mixed (mode_mixed),
        .iaddr      (iaddr),
        .offset     (dec_off),
        .target     (calc_target)
    );

    br_cond_eval u_cond (
        .cond  (eff_cond),
        .flags (flags),
        .pass  (cond_pass)
    );

    assign is_cond_mixed   = (dec_enc == ENC_H16C) || (dec_enc == ENC_M32C);
    assign is_uncond_mixed = (dec_enc == ENC_H16U) || (dec_enc == ENC_M32U);

    // condition source: own field in fixed mode, window otherwise
    always_comb begin
        if (dec_enc == ENC_W32) begin
            eff_cond = dec_cond;
        end else if (blk_active) begin
            eff_cond = blk_cond;
        end else if (dec_has_cond) begin
            eff_cond = dec_cond;
        end else begin
            eff_cond = COND_ALWAYS;
        end
    end

    always_comb begin
        state_d = '0;
        if (in_valid) begin
            state_d.rdir = dec_rdir;
            if (dec_enc != ENC_NONE) begin
                state_d.valid  = 1'b1;
                state_d.taken  = cond_pass;
                state_d.target = calc_target;
                state_d.enc    = dec_enc;
                state_d.unpred = (is_cond_mixed && blk_active) ||
                                 (is_uncond_mixed && blk_active && !blk_last);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign br_valid  = state_q.valid;
    assign br_taken  = state_q.taken;
    assign br_target = state_q.target;
    assign br_enc    = state_q.enc;
    assign br_rdir   = state_q.rdir;
    assign br_unpred = state_q.unpred;
endmodule

// File: rtl/br_unit_chk.sv
`timescale 1ns/1ps
module br_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       mode_mixed,
    input logic [1:0] iaddr_lo,
    input logic       blk_active,
    input logic       br_valid,
    input logic       br_taken,
    input logic [1:0] target_lo,
    input logic [2:0] br_enc,
    input logic [1:0] br_rdir,
    input logic       br_unpred
);
    // R13: an idle cycle leaves nothing behind
    a_r13_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!br_valid && !br_taken && br_rdir == 2'd0 && !br_unpred));

    // R10: taken only for a recognised branch
    a_r10_taken_needs_valid: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> br_valid);

    // R4 / R7: redirects never coexist with a branch
    a_r4_redirect_excludes_branch: assert property (@(posedge clk) disable iff (rst)
        (br_rdir != 2'd0) |-> !br_valid);

    // R12: unpredictable only accompanies a branch
    a_r12_unpred_needs_valid: assert property (@(posedge clk) disable iff (rst)
        br_unpred |-> br_valid);

    // R12: no window means nothing unpredictable
    a_r12_unpred_outside_window: assert property (@(posedge clk) disable iff (rst)
        !blk_active |=> !br_unpred);

    // R2: fixed mode yields form 1 with word-aligned displacement
    a_r2_fixed_alignment: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_mixed) |=>
            (!br_valid || (br_enc == 3'd1 && target_lo == $past(iaddr_lo))));

    // R9: mixed mode never yields form 1, displacement is even
    a_r9_mixed_parity: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_mixed) |=>
            (!br_valid || (br_enc != 3'd1 && target_lo[0] == $past(iaddr_lo[0]))));

    // R11: unconditional forms outside a window always pass
    a_r11_uncond_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_mixed && !blk_active) |=>
            (!(br_enc == 3'd3 || br_enc == 3'd5) || br_taken));
endmodule

bind br_unit br_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode_mixed (mode_mixed),
    .iaddr_lo   (iaddr[1:0]),
    .blk_active (blk_active),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .target_lo  (br_target[1:0]),
    .br_enc     (br_enc),
    .br_rdir    (br_rdir),
    .br_unpred  (br_unpred)
);

// File: tb/br_unit_bench.sv
`timescale 1ns/1ps
module br_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        mode_mixed;
    logic [31:0] instr;
    logic [31:0] iaddr;
    logic [3:0]  flags;
    logic        blk_active;
    logic        blk_last;
    logic [3:0]  blk_cond;
    logic        br_valid;
    logic        br_taken;
    logic [31:0] br_target;
    logic [2:0]  br_enc;
    logic [1:0]  br_rdir;
    logic        br_unpred;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    br_unit u_br_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_mixed(mode_mixed),
        .instr(instr), .iaddr(iaddr), .flags(flags), .blk_active(blk_active),
        .blk_last(blk_last), .blk_cond(blk_cond), .br_valid(br_valid),
        .br_taken(br_taken), .br_target(br_target), .br_enc(br_enc),
        .br_rdir(br_rdir), .br_unpred(br_unpred)
    );

    // ---- independent instruction builders ----
    function automatic logic [31:0] mk_w32(input logic [3:0] c, input int off);
        logic [31:0] o = off;
        return {c, 4'b1010, o[25:2]};
    endfunction

    function automatic logic [31:0] mk_h16c(input logic [3:0] c, input int off);
        logic [31:0] o = off;
        return {16'h0000, 4'b1101, c, o[8:1]};
    endfunction

    function automatic logic [31:0] mk_h16u(input int off);
        logic [31:0] o = off;
        return {16'h0000, 5'b11100, o[11:1]};
    endfunction

    function automatic logic [31:0] mk_m32c(input logic [3:0] c, input int off);
        logic [31:0] o = off;
        logic [15:0] h1, h2;
        h1 = {5'b11110, o[20], c, o[17:12]};
        h2 = {2'b10, o[18], 1'b0, o[19], o[11:1]};
        return {h2, h1};
    endfunction

    function automatic logic [31:0] mk_m32u(input int off);
        logic [31:0] o = off;
        logic        j1, j2;
        logic [15:0] h1, h2;
        j1 = ~(o[23] ^ o[24]);
        j2 = ~(o[22] ^ o[24]);
        h1 = {5'b11110, o[24], o[21:12]};
        h2 = {2'b10, j1, 1'b1, j2, o[11:1]};
        return {h2, h1};
    endfunction

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    // ---- drive one word on the falling edge, sample after the next rising edge ----
    task automatic apply(input logic mm, input logic [31:0] w, input logic [31:0] a,
                         input logic [3:0] f, input logic ba, input logic bl,
                         input logic [3:0] bc, input logic iv);
        @(negedge clk);
        in_valid = iv; mode_mixed = mm; instr = w; iaddr = a; flags = f;
        blk_active = ba; blk_last = bl; blk_cond = bc;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic v, input logic t,
                              input logic [31:0] tg, input logic [2:0] e,
                              input logic [1:0] r, input logic u);
        checks++;
        if (br_valid !== v || br_taken !== t || br_target !== tg ||
            br_enc !== e || br_rdir !== r || br_unpred !== u) begin
            errors++;
            $display("FAIL %s: got v=%0b t=%0b tgt=%h enc=%0d rd=%0d u=%0b, exp v=%0b t=%0b tgt=%h enc=%0d rd=%0d u=%0b",
                     tag, br_valid, br_taken, br_target, br_enc, br_rdir, br_unpred,
                     v, t, tg, e, r, u);
        end
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        rst = 1'b1;
        apply(1'b0, mk_w32(4'hE, 64), 32'h100, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R1 reset clears outputs", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fixed();
        logic [31:0] a = 32'h1000_0000;
        apply(1'b0, mk_w32(4'hE, 33554428), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R2 fixed max positive", 1, 1, a + 32'd8 + 32'd33554428, 3'd1, 2'd0, 0);
        apply(1'b0, mk_w32(4'hE, -33554432), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R2 fixed max negative", 1, 1, a + 32'd8 - 32'd33554432, 3'd1, 2'd0, 0);
        apply(1'b0, {4'hF, 4'hA, 24'h000010}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R2 cond 1111 not a branch", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        apply(1'b0, mk_w32(4'h0, -4), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R10 fixed EQ with Z clear", 1, 0, a + 32'd4, 3'd1, 2'd0, 0);
    endtask

    task automatic t_h16c();
        logic [31:0] a = 32'h0000_4002;
        apply(1'b1, mk_h16c(4'h0, 254), a, 4'b0100, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R3 short cond max positive", 1, 1, a + 32'd4 + 32'd254, 3'd2, 2'd0, 0);
        apply(1'b1, mk_h16c(4'h1, -256), a, 4'b0100, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R3 short cond max negative NE", 1, 0, a + 32'd4 - 32'd256, 3'd2, 2'd0, 0);
        apply(1'b1, mk_h16c(4'hE, 8), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R4 cond 1110 perm undefined", 0, 0, 32'h0, 3'd0, 2'd1, 0);
        apply(1'b1, mk_h16c(4'hF, 8), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R4 cond 1111 system call", 0, 0, 32'h0, 3'd0, 2'd2, 0);
    endtask

    task automatic t_h16u();
        logic [31:0] a = 32'h0008_0000;
        apply(1'b1, mk_h16u(2046), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R5 short uncond max positive", 1, 1, a + 32'd4 + 32'd2046, 3'd3, 2'd0, 0);
        apply(1'b1, mk_h16u(-2048), a, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R5 short uncond max negative", 1, 1, a + 32'd4 - 32'd2048, 3'd3, 2'd0, 0);
    endtask

    task automatic t_m32c();
        logic [31:0] a = 32'h0040_0000;
        apply(1'b1, mk_m32c(4'h2, 1048574), a, 4'b0010, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R6 long cond max positive CS", 1, 1, a + 32'd4 + 32'd1048574, 3'd4, 2'd0, 0);
        apply(1'b1, mk_m32c(4'hC, -1048576), a, 4'b1000, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R6 long cond max negative GT fails", 1, 0, a + 32'd4 - 32'd1048576, 3'd4, 2'd0, 0);
        apply(1'b1, mk_m32c(4'hE, 16), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R7 cond 1110 related", 0, 0, 32'h0, 3'd0, 2'd3, 0);
        apply(1'b1, mk_m32c(4'hF, 16), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R7 cond 1111 related", 0, 0, 32'h0, 3'd0, 2'd3, 0);
    endtask

    task automatic t_m32u();
        logic [31:0] a = 32'h0100_0000;
        apply(1'b1, mk_m32u(16777214), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 long uncond max positive", 1, 1, a + 32'd4 + 32'd16777214, 3'd5, 2'd0, 0);
        apply(1'b1, mk_m32u(-16777216), a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 long uncond max negative", 1, 1, a + 32'd4 - 32'd16777216, 3'd5, 2'd0, 0);
        // hand-set J bits: S=0,J=11 -> 0 ; S=0,J=00 -> 0x00C00000
        apply(1'b1, {16'hB800, 16'hF000}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 S0 J11 inversion", 1, 1, a + 32'd4, 3'd5, 2'd0, 0);
        apply(1'b1, {16'h9000, 16'hF000}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 S0 J00 inversion", 1, 1, a + 32'd4 + 32'h00C0_0000, 3'd5, 2'd0, 0);
        // S=1,J=11 -> -4194304 ; S=1,J=00 -> -16777216
        apply(1'b1, {16'hB800, 16'hF400}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 S1 J11 inversion", 1, 1, a + 32'd4 - 32'd4194304, 3'd5, 2'd0, 0);
        apply(1'b1, {16'h9000, 16'hF400}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R8 S1 J00 inversion", 1, 1, a + 32'd4 - 32'd16777216, 3'd5, 2'd0, 0);
        apply(1'b1, {16'hD000, 16'hF000}, a, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R13 wide word outside branch space", 0, 0, 32'h0, 3'd0, 2'd0, 0);
    endtask

    task automatic t_cond_table();
        for (int c = 0; c < 15; c++) begin
            for (int f = 0; f < 16; f++) begin
                apply(1'b0, mk_w32(4'(c), 0), 32'h2000, 4'(f), 1'b0, 1'b0, 4'h0, 1'b1);
                expect_out("R10 condition table", 1, cond_ok(4'(c), 4'(f)),
                           32'h2008, 3'd1, 2'd0, 0);
            end
        end
    endtask

    task automatic t_window();
        logic [31:0] a = 32'h0000_8000;
        apply(1'b1, mk_m32c(4'h0, 64), a, 4'b0100, 1'b1, 1'b0, 4'h1, 1'b1);
        expect_out("R11 R12 long cond uses window NE", 1, 0, a + 32'd68, 3'd4, 2'd0, 1);
        apply(1'b1, mk_h16c(4'h0, -2), a, 4'b0100, 1'b1, 1'b1, 4'h0, 1'b1);
        expect_out("R12 short cond in window last", 1, 1, a + 32'd2, 3'd2, 2'd0, 1);
        apply(1'b1, mk_h16u(32), a, 4'b0000, 1'b1, 1'b1, 4'h0, 1'b1);
        expect_out("R11 R12 short uncond last EQ fails", 1, 0, a + 32'd36, 3'd3, 2'd0, 0);
        apply(1'b1, mk_h16u(32), a, 4'b0000, 1'b1, 1'b0, 4'hE, 1'b1);
        expect_out("R12 short uncond not last", 1, 1, a + 32'd36, 3'd3, 2'd0, 1);
        apply(1'b1, mk_m32u(-512), a, 4'b0000, 1'b1, 1'b0, 4'h5, 1'b1);
        expect_out("R12 long uncond not last PL", 1, 1, a + 32'd4 - 32'd512, 3'd5, 2'd0, 1);
        apply(1'b1, mk_m32u(-512), a, 4'b1000, 1'b1, 1'b1, 4'h5, 1'b1);
        expect_out("R11 long uncond last PL fails", 1, 0, a + 32'd4 - 32'd512, 3'd5, 2'd0, 0);
        apply(1'b0, mk_w32(4'h0, 8), a, 4'b0100, 1'b1, 1'b0, 4'h1, 1'b1);
        expect_out("R11 fixed ignores window", 1, 1, a + 32'd16, 3'd1, 2'd0, 0);
    endtask

    task automatic t_idle();
        apply(1'b0, mk_w32(4'hE, 64), 32'h300, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0);
        expect_out("R13 in_valid low", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        apply(1'b1, mk_h16c(4'hF, 4), 32'h300, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0);
        expect_out("R13 in_valid low hides redirect", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        apply(1'b0, 32'hE3A0_0000, 32'h300, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R13 fixed non-branch word", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        apply(1'b1, 32'h0000_4600, 32'h300, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R13 short non-branch word", 0, 0, 32'h0, 3'd0, 2'd0, 0);
        apply(1'b1, mk_h16c(4'h0, 254), 32'hFFFF_FF00, 4'b0100, 1'b0, 1'b0, 4'h0, 1'b1);
        expect_out("R9 target wraps", 1, 1, 32'h0000_0002, 3'd2, 2'd0, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; mode_mixed = 1'b0; instr = '0; iaddr = '0;
        flags = '0; blk_active = 1'b0; blk_last = 1'b0; blk_cond = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_fixed();
        t_h16c();
        t_h16u();
        t_m32c();
        t_m32u();
        t_cond_table();
        t_window();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule